// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate with Run-Time Round and Saturate

This block multiplies two 18-bit operands and can sum the products in a wide accumulator. Each operand carries its own per-cycle flag that says whether it is read as two's complement or as an unsigned number, so all four sign pairings are available without reconfiguration. The accumulated value then passes through an optional round-half-up step at a fixed fraction boundary, followed by an optional clamp to a narrower signed word. A second, independent rounder produces a chained copy of the result, rounded at its own boundary.

All mode bits are captured together with the operands when a valid input is accepted. Each result is therefore processed with the mode that belonged to its own operands, even when inputs arrive back to back with different modes. A sticky flag records that a clamp has taken place. It stays set until reset.

Top module: `mac_rndsat`

## Requirements
- R1: A valid input accepted at a rising edge gives `out_vld` high for one cycle with its result on `res_o` after the third rising edge. It gives `chain_vld` high with `chain_o` one cycle after that.
- R2: `sgn_a`=1 reads `a_i` as 18-bit two's complement and `sgn_a`=0 reads it as unsigned. `sgn_b` does the same for `b_i`. All four pairings give the exact product.
- R3: With `acc_en`=1 the product is added to the 44-bit accumulator. With `acc_en`=0 the accumulator is loaded with the product. The accumulator changes only on a valid input.
- R4: With `rnd_en`=1 the accumulated value has 2^(RND_POS-1) added to it, and then its bits below RND_POS are cleared (round half up, default RND_POS=16).
- R5: With `rnd_en`=0 and `sat_en`=0, `res_o` equals the accumulated value unchanged.
- R6: With `sat_en`=1, a value above 2^(SAT_W-1)-1 gives exactly that maximum, and a value below -2^(SAT_W-1) gives exactly that minimum (default SAT_W=36). With `sat_en`=0 no clamp is applied.
- R7: When both `rnd_en` and `sat_en` are 1, the clamp is applied to the rounded value. A value that lies in range but rounds above the maximum therefore gives the maximum.
- R8: `ovf_o` goes high once a clamp occurs and stays high until reset. Reset clears it, and a result that needs no clamp does not set it.
- R9: `chain_o` is `res_o` rounded half up at CHAIN_POS (default 20) when the captured `chain_rnd_en` is 1, and equals `res_o` when it is 0. The chained rounding leaves `res_o` untouched.
- R10: Mode bits are taken at the same edge as their operands. Back-to-back inputs with different modes each get their own mode.
- R11: While no result is delivered (`out_vld`=0), `res_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Operands and mode bits are valid this cycle |
| a_i | input | 18 | Multiplicand |
| b_i | input | 18 | Multiplier |
| sgn_a | input | 1 | 1: multiplicand is signed, 0: unsigned |
| sgn_b | input | 1 | 1: multiplier is signed, 0: unsigned |
| rnd_en | input | 1 | Round the result at RND_POS |
| chain_rnd_en | input | 1 | Round the chained copy at CHAIN_POS |
| sat_en | input | 1 | Clamp the result to SAT_W signed bits |
| acc_en | input | 1 | 1: add to accumulator, 0: load accumulator |
| out_vld | output | 1 | Result valid |
| res_o | output | 44 | Rounded/saturated result |
| ovf_o | output | 1 | Sticky clamp flag |
| chain_vld | output | 1 | Chained result valid |
| chain_o | output | 44 | Chained result after second rounder |

## Verification
The assertions delay the raw control inputs by a fixed number of cycles and trust them only when a valid result comes out. They therefore assume that the mode bits seen at the edge that accepts an input are the ones that belong to it. They also assume that `rnd_en`, `sat_en` and `chain_rnd_en` are never unknown. The stimulus drives every control bit to a defined 0 or 1 on the falling edge and holds it across the accepting rising edge. It keeps reset low for several cycles before the first input is sent. It picks operand values that sit exactly on the rounding halfway points and next to the clamp limits, both above and below them.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef struct packed {
    logic sgn_a;
    logic sgn_b;
    logic rnd;
    logic crnd;
    logic sat;
    logic acc;
  } mrs_mode_t;
endpackage

// File: rtl/mrs_opext.sv
module mrs_opext #(
  parameter int W = 18
) (
  input  logic [W-1:0] d,
  input  logic         sgn,
  output logic [W:0]   q
);
  always_comb begin
    q = {sgn & d[W-1], d};
  end
endmodule

// File: rtl/mrs_mac.sv
module mrs_mac #(
  parameter int AW    = 18,
  parameter int BW    = 18,
  parameter int ACC_W = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             acc_en,
  input  logic [AW:0]      a_x,
  input  logic [BW:0]      b_x,
  output logic [ACC_W-1:0] acc_q
);
  localparam int PW = AW + BW + 2;

  logic signed [PW-1:0] prod;
  logic [ACC_W-1:0]     prod_ext;
  logic [ACC_W-1:0]     acc_d;

  always_comb begin
    prod     = $signed(a_x) * $signed(b_x);
    prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
    acc_d    = acc_en ? (acc_q + prod_ext) : prod_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/mrs_round.sv
module mrs_round #(
  parameter int W   = 44,
  parameter int POS = 16,
  parameter int OW  = 45
) (
  input  logic          en,
  input  logic [W-1:0]  d,
  output logic [OW-1:0] q
);
  localparam logic [W:0] HALF = (W+1)'(1) << (POS-1);
  localparam logic [W:0] LOWM = ((W+1)'(1) << POS) - (W+1)'(1);

  logic [W:0] wide;
  logic [W:0] sum;

  always_comb begin
    wide = {d[W-1], d};
    sum  = wide + HALF;
    q    = OW'(en ? (sum & ~LOWM) : wide);
  end
endmodule

// File: rtl/mrs_sat.sv
module mrs_sat #(
  parameter int W  = 45,
  parameter int OW = 44,
  parameter int SW = 36
) (
  input  logic          en,
  input  logic [W-1:0]  d,
  output logic [OW-1:0] q,
  output logic          hit
);
  localparam logic [W-1:0] MAXW = {{(W-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic [W-1:0] MINW = {{(W-SW+1){1'b1}}, {(SW-1){1'b0}}};

  logic over;
  logic under;

  always_comb begin
    over  = en && ($signed(d) > $signed(MAXW));
    under = en && ($signed(d) < $signed(MINW));
    hit   = over | under;
    if (over) begin
      q = OW'(MAXW);
    end else if (under) begin
      q = OW'(MINW);
    end else begin
      q = OW'(d);
    end
  end
endmodule

// File: rtl/mac_rndsat.sv
module mac_rndsat #(
  parameter int AW       = 18,
  parameter int BW       = 18,
  parameter int ACC_W    = 44,
  parameter int RND_POS  = 16,
  parameter int CHAIN_POS = 20,
  parameter int SAT_W    = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [AW-1:0]    a_i,
  input  logic [BW-1:0]    b_i,
  input  logic             sgn_a,
  input  logic             sgn_b,
  input  logic             rnd_en,
  input  logic             chain_rnd_en,
  input  logic             sat_en,
  input  logic             acc_en,
  output logic             out_vld,
  output logic [ACC_W-1:0] res_o,
  output logic             ovf_o,
  output logic             chain_vld,
  output logic [ACC_W-1:0] chain_o
);
  import mrs_pkg::*;

  localparam int RW = ACC_W + 1;

  // reset synchronizer: asynchronous assert, synchronous release
  logic rs0_q, rs1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_sync_n = rs1_q;

  // stage 1: operand and mode capture
  mrs_mode_t       mode_in, m1_q, m2_q;
  logic [AW-1:0]   a_q;
  logic [BW-1:0]   b_q;
  logic            v1_q, v2_q, v3_q, v4_q;

  always_comb begin
    mode_in = '{sgn_a: sgn_a, sgn_b: sgn_b, rnd: rnd_en,
                crnd: chain_rnd_en, sat: sat_en, acc: acc_en};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v1_q <= 1'b0;
      a_q  <= '0;
      b_q  <= '0;
      m1_q <= '0;
    end else begin
      v1_q <= in_vld;
      if (in_vld) begin
        a_q  <= a_i;
        b_q  <= b_i;
        m1_q <= mode_in;
      end
    end
  end

  // stage 2: sign extension, multiply, accumulate
  logic [AW:0]      a_x;
  logic [BW:0]      b_x;
  logic [ACC_W-1:0] acc_q;

  mrs_opext #(.W(AW)) u_ext_a (.d(a_q), .sgn(m1_q.sgn_a), .q(a_x));
  mrs_opext #(.W(BW)) u_ext_b (.d(b_q), .sgn(m1_q.sgn_b), .q(b_x));

  mrs_mac #(.AW(AW), .BW(BW), .ACC_W(ACC_W)) u_mac (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (v1_q),
    .acc_en (m1_q.acc),
    .a_x    (a_x),
    .b_x    (b_x),
    .acc_q  (acc_q)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v2_q <= 1'b0;
      m2_q <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        m2_q <= m1_q;
      end
    end
  end

  // stage 3: round, then saturate the rounded value
  logic [RW-1:0]    rnd_w;
  logic [ACC_W-1:0] sat_w;
  logic             sat_hit;
  logic [ACC_W-1:0] res_q;
  logic             ovf_q, ovf_d;
  logic             crnd3_q;

  mrs_round #(.W(ACC_W), .POS(RND_POS), .OW(RW)) u_rnd1 (
    .en (m2_q.rnd),
    .d  (acc_q),
    .q  (rnd_w)
  );

  mrs_sat #(.W(RW), .OW(ACC_W), .SW(SAT_W)) u_sat (
    .en  (m2_q.sat),
    .d   (rnd_w),
    .q   (sat_w),
    .hit (sat_hit)
  );

  always_comb begin
    ovf_d = ovf_q | (v2_q & sat_hit);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v3_q    <= 1'b0;
      res_q   <= '0;
      ovf_q   <= 1'b0;
      crnd3_q <= 1'b0;
    end else begin
      v3_q  <= v2_q;
      ovf_q <= ovf_d;
      if (v2_q) begin
        res_q   <= sat_w;
        crnd3_q <= m2_q.crnd;
      end
    end
  end

  // stage 4: second rounder on the chained copy
  logic [ACC_W-1:0] chain_w;
  logic [ACC_W-1:0] chain_q;

  mrs_round #(.W(ACC_W), .POS(CHAIN_POS), .OW(ACC_W)) u_rnd2 (
    .en (crnd3_q),
    .d  (res_q),
    .q  (chain_w)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v4_q    <= 1'b0;
      chain_q <= '0;
    end else begin
      v4_q <= v3_q;
      if (v3_q) begin
        chain_q <= chain_w;
      end
    end
  end

  assign out_vld   = v3_q;
  assign res_o     = res_q;
  assign ovf_o     = ovf_q;
  assign chain_vld = v4_q;
  assign chain_o   = chain_q;
endmodule

// File: rtl/mac_rndsat_chk.sv
module mac_rndsat_chk #(
  parameter int ACC_W   = 44,
  parameter int RND_POS = 16,
  parameter int SAT_W   = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rnd_en,
  input logic             chain_rnd_en,
  input logic             sat_en,
  input logic             out_vld,
  input logic [ACC_W-1:0] res_o,
  input logic             ovf_o,
  input logic             chain_vld,
  input logic [ACC_W-1:0] chain_o
);
  localparam logic [ACC_W-1:0] MAXV = {{(ACC_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MINV = {{(ACC_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

  logic [1:0] cnt_q;
  logic [2:0] sat_d, rnd_d;
  logic [3:0] crnd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sat_d  <= '0;
      rnd_d  <= '0;
      crnd_d <= '0;
    end else begin
      if (cnt_q != 2'd3) cnt_q <= cnt_q + 2'd1;
      sat_d  <= {sat_d[1:0], sat_en};
      rnd_d  <= {rnd_d[1:0], rnd_en};
      crnd_d <= {crnd_d[2:0], chain_rnd_en};
    end
  end

  // R1: chained result follows the main result by one cycle
  a_r1_chain_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != 2'd0) |-> (chain_vld == $past(out_vld)));

  // R6: a saturated result is inside the signed output range
  a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && sat_d[2]) |-> (($signed(res_o) <= $signed(MAXV)) &&
                               ($signed(res_o) >= $signed(MINV))));

  // R4: a rounded, unclamped result has cleared low bits
  a_r4_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && rnd_d[2] && !sat_d[2]) |-> (res_o[RND_POS-1:0] == '0));

  // R8: the overflow flag never falls outside reset
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  // R11: result holds when nothing is delivered
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q != 2'd0) && !out_vld) |-> $stable(res_o));

  // R9: chained copy equals the result when its rounder is off
  a_r9_chain_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q != 2'd0) && chain_vld && !crnd_d[3]) |-> (chain_o == $past(res_o)));
endmodule

bind mac_rndsat mac_rndsat_chk #(
  .ACC_W   (ACC_W),
  .RND_POS (RND_POS),
  .SAT_W   (SAT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .rnd_en       (rnd_en),
  .chain_rnd_en (chain_rnd_en),
  .sat_en       (sat_en),
  .out_vld      (out_vld),
  .res_o        (res_o),
  .ovf_o        (ovf_o),
  .chain_vld    (chain_vld),
  .chain_o      (chain_o)
);

// File: tb/mac_rndsat_bench.sv
`timescale 1ns/1ps
module mac_rndsat_bench;
  localparam int ACC_W = 44;
  localparam int RP    = 16;
  localparam int CP    = 20;
  localparam int SW    = 36;

  localparam longint MAXV = (64'sd1 <<< (SW-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (SW-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [17:0] a_i = '0, b_i = '0;
  logic sgn_a = 0, sgn_b = 0, rnd_en = 0, chain_rnd_en = 0, sat_en = 0, acc_en = 0;
  logic out_vld, ovf_o, chain_vld;
  logic [ACC_W-1:0] res_o, chain_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint m_acc = 0;
  bit     m_ovf = 0;

  always #10 clk = ~clk;

  mac_rndsat #(.ACC_W(ACC_W), .RND_POS(RP), .CHAIN_POS(CP), .SAT_W(SW)) u_mac_rndsat (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .a_i(a_i), .b_i(b_i),
    .sgn_a(sgn_a), .sgn_b(sgn_b), .rnd_en(rnd_en), .chain_rnd_en(chain_rnd_en),
    .sat_en(sat_en), .acc_en(acc_en), .out_vld(out_vld), .res_o(res_o),
    .ovf_o(ovf_o), .chain_vld(chain_vld), .chain_o(chain_o)
  );

  function automatic longint sx(longint x, int n);
    longint m = (64'sd1 <<< n) - 1;
    longint y = x & m;
    if (y[n-1]) y = y - (64'sd1 <<< n);
    return y;
  endfunction

  function automatic longint rnd_at(longint x, int pos);
    return (x + (64'sd1 <<< (pos-1))) & ~((64'sd1 <<< pos) - 1);
  endfunction

  // expected result and chained copy for one input, updating model state
  task automatic model(input logic [17:0] a, input logic [17:0] b,
                       input bit sa, input bit sb, input bit r, input bit cr,
                       input bit s, input bit ac, output longint er, output longint ec);
    longint av = sa ? sx(longint'(a), 18) : longint'(a);
    longint bv = sb ? sx(longint'(b), 18) : longint'(b);
    longint v;
    m_acc = ac ? sx(m_acc + av * bv, ACC_W) : sx(av * bv, ACC_W);
    v = r ? rnd_at(m_acc, RP) : m_acc;
    if (s && v > MAXV) begin er = MAXV; m_ovf = 1; end
    else if (s && v < MINV) begin er = MINV; m_ovf = 1; end
    else er = sx(v, ACC_W);
    ec = cr ? sx(rnd_at(er, CP), ACC_W) : er;
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [17:0] a, input logic [17:0] b, input bit sa, input bit sb,
                       input bit r, input bit cr, input bit s, input bit ac);
    in_vld = 1; a_i = a; b_i = b; sgn_a = sa; sgn_b = sb;
    rnd_en = r; chain_rnd_en = cr; sat_en = s; acc_en = ac;
  endtask

  task automatic idle();
    in_vld = 0; a_i = '0; b_i = '0; sgn_a = 0; sgn_b = 0;
    rnd_en = 0; chain_rnd_en = 0; sat_en = 0; acc_en = 0;
  endtask

  // one input, result checked three edges later, chain one edge after
  task automatic op(input string req, input logic [17:0] a, input logic [17:0] b,
                    input bit sa, input bit sb, input bit r, input bit cr,
                    input bit s, input bit ac);
    longint er, ec;
    model(a, b, sa, sb, r, cr, s, ac, er, ec);
    drive(a, b, sa, sb, r, cr, s, ac);
    @(negedge clk); idle();
    @(negedge clk);
    @(negedge clk);
    chk({req, " R1 out_vld"}, longint'(out_vld), 1);
    chk({req, " res_o"}, longint'($signed(res_o)), er);
    chk({req, " R8 ovf_o"}, longint'(ovf_o), longint'(m_ovf));
    @(negedge clk);
    chk({req, " R1 chain_vld"}, longint'(chain_vld), 1);
    chk({req, " R1 out_vld drop"}, longint'(out_vld), 0);
    chk({req, " chain_o"}, longint'($signed(chain_o)), ec);
  endtask

  task automatic do_reset();
    rst_n = 0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    m_acc = 0; m_ovf = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R8 reset ovf_o", longint'(ovf_o), 0);
    chk("R1 reset out_vld", longint'(out_vld), 0);
    chk("R1 reset chain_vld", longint'(chain_vld), 0);
    chk("R11 reset res_o", longint'(res_o), 0);
  endtask

  task automatic t_signs();
    op("R2 ss", 18'h3FFFD, 18'd5, 1, 1, 0, 0, 0, 0);
    op("R2 su", 18'h3FFFF, 18'h3FFFF, 1, 0, 0, 0, 0, 0);
    op("R2 us", 18'h3FFFF, 18'h3FFFF, 0, 1, 0, 0, 0, 0);
    op("R2 R5 uu", 18'h3FFFF, 18'h3FFFF, 0, 0, 0, 0, 0, 0);
    op("R2 ss min", 18'h20000, 18'h20000, 1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_round();
    op("R4 above half", 18'd3, 18'h03000, 0, 0, 1, 0, 0, 0);
    op("R4 exact half", 18'd1, 18'h08000, 0, 0, 1, 0, 0, 0);
    op("R4 below half", 18'd1, 18'h07FFF, 0, 0, 1, 0, 0, 0);
    op("R4 neg half", 18'h3FFFF, 18'h08000, 1, 0, 1, 0, 0, 0);
    op("R4 neg past half", 18'h3FFFF, 18'h08001, 1, 0, 1, 0, 0, 0);
    op("R5 round off", 18'd1, 18'h07FFF, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_acc();
    op("R3 load", 18'd100, 18'd100, 1, 1, 0, 0, 0, 0);
    op("R3 add", 18'd200, 18'd3, 1, 1, 0, 0, 0, 1);
    op("R3 add neg", 18'h3FF00, 18'd50, 1, 1, 0, 0, 0, 1);
    op("R3 reload", 18'd7, 18'd6, 1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_sat();
    op("R6 no sat uu", 18'h3FFFF, 18'h3FFFF, 0, 0, 0, 0, 0, 0);
    op("R6 sat pos", 18'h3FFFF, 18'h3FFFF, 0, 0, 0, 0, 1, 0);
    op("R6 near min", 18'h20000, 18'h3FFFF, 1, 0, 0, 0, 1, 0);
    op("R6 sat neg acc", 18'h20000, 18'h3FFFF, 1, 0, 0, 0, 1, 1);
  endtask

  task automatic t_order();
    do_reset();
    op("R7 in range no round", 18'd261888, 18'd131200, 0, 0, 0, 0, 1, 0);
    op("R7 round then sat", 18'd261888, 18'd131200, 0, 0, 1, 0, 1, 0);
  endtask

  task automatic t_chain();
    op("R9 chain round", 18'd1024, 18'd512, 0, 0, 0, 1, 0, 0);
    op("R9 chain off", 18'd1024, 18'd512, 0, 0, 0, 0, 0, 0);
    op("R9 chain below", 18'd1023, 18'd512, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_sticky();
    op("R8 stays set", 18'd2, 18'd2, 1, 1, 0, 0, 1, 0);
    do_reset();
    chk("R8 cleared by reset", longint'(ovf_o), 0);
    op("R8 no clamp no set", 18'd2, 18'd2, 1, 1, 0, 0, 1, 0);
  endtask

  task automatic t_b2b();
    longint e1, c1, e2, c2;
    model(18'h3FFFF, 18'd2, 1, 1, 0, 0, 0, 0, e1, c1);
    drive(18'h3FFFF, 18'd2, 1, 1, 0, 0, 0, 0);
    @(negedge clk);
    model(18'h3FFFF, 18'd2, 0, 0, 0, 1, 0, 0, e2, c2);
    drive(18'h3FFFF, 18'd2, 0, 0, 0, 1, 0, 0);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R10 first res", longint'($signed(res_o)), e1);
    chk("R10 first vld", longint'(out_vld), 1);
    @(negedge clk);
    chk("R10 second res", longint'($signed(res_o)), e2);
    chk("R10 first chain", longint'($signed(chain_o)), c1);
    @(negedge clk);
    chk("R10 second chain", longint'($signed(chain_o)), c2);
  endtask

  task automatic t_hold();
    longint er, ec;
    op("R11 setup", 18'd9, 18'd9, 1, 1, 0, 0, 0, 0);
    er = 81;
    repeat (3) @(negedge clk);
    chk("R11 out_vld idle", longint'(out_vld), 0);
    chk("R11 res held", longint'($signed(res_o)), er);
    chk("R11 chain_vld idle", longint'(chain_vld), 0);
    ec = er;
    chk("R11 chain held", longint'($signed(chain_o)), ec);
  endtask

  initial begin
    t_reset();
    t_signs();
    t_round();
    t_acc();
    t_sat();
    t_order();
    t_chain();
    t_sticky();
    t_b2b();
    t_hold();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule